// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one complete management frame towards an external PHY. It drives a management clock and a data line that is split into a data output, an output enable and a data input, so a pad or tristate buffer outside the block forms the shared wire. The host raises `start` for one cycle together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. While the frame runs `busy` stays high. A one-cycle `done` pulse marks the return to idle, and on a read the 16 captured bits are then on `rdata`.

Every frame has exactly 65 management clocks. It opens with a 32-bit preamble of ones and carries the start and opcode fields and both addresses. A two-bit turnaround follows, during which the master lets go of the line. Then come 16 data bits and one final clock with the line released. Each half-period of the management clock lasts `HALF_DIV` system clocks. The default suits a 100 MHz system clock, which gives 2.5 MHz on the management clock. Data and enable change while the clock is low. The input is captured at the end of the high half, just before the clock falls.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset `mdc`, `mdo`, `mdo_en`, `busy` and `done` are low and `rdata` is zero.
- R2: Frame bits 0 to 31 are ones, driven with `mdo_en` high.
- R3: Bits 32 and 33 are 0 then 1. Bits 34 and 35 are the opcode: 1 then 0 for a read (`rd`=1), 0 then 1 for a write, all driven.
- R4: Bits 36 to 40 carry `phy_addr`, most significant bit first. Bits 41 to 45 carry `reg_addr`, most significant bit first. All are driven.
- R5: In bits 46 and 47 (the turnaround) `mdo_en` is low in both reads and writes.
- R6: In a write, bits 48 to 63 carry `wdata` most significant bit first, driven. In a read, `mdo_en` stays low from bit 46 to the end of the frame.
- R7: A frame has exactly 65 rising edges of `mdc`, and during bit 64 `mdo_en` is low.
- R8: Each low and each high half of `mdc` within a frame lasts `HALF_DIV` system clocks. `mdo` and `mdo_en` change only while `mdc` is low.
- R9: In a read, `mdi` is captured in the last system clock of the high half of bits 48 to 63. The bit from bit 48 ends up in `rdata[15]` and the bit from bit 63 in `rdata[0]`. `rdata` changes only in the cycle when `done` rises after a read. A write leaves it unchanged.
- R10: After bit 64 the lines stay idle (`mdc`, `mdo`, `mdo_en` low) for `HALF_DIV` system clocks. Then `done` is high for exactly one cycle while `busy` falls. The time from the `start` edge to `done` is 131*`HALF_DIV` system clocks.
- R11: `start` is ignored while `busy` is high: the running frame continues unchanged and no new frame follows it.
- R12: `mdo` is low whenever `mdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data to write |
| rdata | output | 16 | Data captured by the last read |
| busy | output | 1 | High while a frame runs |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output value |
| mdo_en | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input value |

## Verification
The bench builds the block with `HALF_DIV` = 2, so a frame takes 262 system clocks. At that value a one-cycle error in either half-period shows up as a clearly wrong run length and a wrong frame length, while many frames still fit into a short run. The bench's PHY model changes `mdi` on every rising `mdc` edge. A block that captures at the wrong point in the high half, or one bit early or late, therefore picks up a shifted read value.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_en,
  input  logic        mdi
);
  localparam int NBITS = 65;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [6:0] FIRST_DATA = 7'd48;
  localparam logic [6:0] LAST_DATA = 7'd63;
  localparam logic [6:0] LAST_BIT = 7'd64;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_END} st_t;

  st_t              st;
  logic [DW-1:0]    div;
  logic [6:0]       bitn;
  logic [NBITS-1:0] txd, txe;
  logic             rd_q;
  logic [15:0]      sh;

  wire tick   = (div == DW'(HALF_DIV - 1));
  wire in_win = rd_q && (bitn >= FIRST_DATA) && (bitn <= LAST_DATA);

  assign busy   = (st != S_IDLE);
  assign mdo    = txd[NBITS-1];
  assign mdo_en = txe[NBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      div   <= '0;
      bitn  <= '0;
      txd   <= '0;
      txe   <= '0;
      rd_q  <= 1'b0;
      sh    <= '0;
      rdata <= '0;
      done  <= 1'b0;
      mdc   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_LO;
          div  <= '0;
          bitn <= '0;
          rd_q <= rd;
          txd  <= {{32{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy_addr, reg_addr,
                   2'b00, (rd ? 16'h0000 : wdata), 1'b0};
          txe  <= {{46{1'b1}}, 2'b00, {16{~rd}}, 1'b0};
        end
        S_LO: if (tick) begin
          st  <= S_HI;
          mdc <= 1'b1;
          div <= '0;
        end else div <= div + 1'b1;
        S_HI: if (tick) begin
          div <= '0;
          mdc <= 1'b0;
          if (in_win) sh <= {sh[14:0], mdi};
          if (bitn == LAST_BIT) begin
            st  <= S_END;
            txd <= '0;
            txe <= '0;
          end else begin
            st   <= S_LO;
            bitn <= bitn + 7'd1;
            txd  <= {txd[NBITS-2:0], 1'b0};
            txe  <= {txe[NBITS-2:0], 1'b0};
          end
        end else div <= div + 1'b1;
        S_END: if (tick) begin
          st   <= S_IDLE;
          done <= 1'b1;
          div  <= '0;
          if (rd_q) rdata <= sh;
        end else div <= div + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] rdata,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdo,
  input logic        mdo_en
);
  logic [6:0] rises;
  logic       mdc_q;
  wire        rise_now = mdc && !mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises <= '0;
      mdc_q <= 1'b0;
    end else begin
      mdc_q <= mdc;
      if (!busy) rises <= '0;
      else if (rise_now) rises <= rises + 7'd1;
    end
  end

  assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && rises < 7'd32) |-> (mdo_en && mdo));
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && (rises == 7'd46 || rises == 7'd47)) |-> !mdo_en);
  assert_trailer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && rises == 7'd64) |-> !mdo_en);
  assert_rise_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rises <= 7'd65));
  assert_stable_while_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_en)));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdo && !mdo_en));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_start_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_released_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mdo_en |-> !mdo);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rdata(rdata), .busy(busy),
  .done(done), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en)
);

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int NVEC = 6;

  // {rd, phy, reg, wdata, phy response}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'hFFFF, 16'h0000},
    {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
    {1'b0, 5'h15, 5'h0A, 16'h8001, 16'hFFFF},
    {1'b1, 5'h00, 5'h01, 16'h0000, 16'h0000},
    {1'b1, 5'h12, 5'h1B, 16'h5555, 16'hFFFF},
    {1'b0, 5'h0A, 5'h15, 16'h1234, 16'h0F0F}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic busy, done, mdc, mdo, mdo_en, mdi;

  int checks = 0, fails = 0, cyc = 0;
  int rcnt = 0, hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0;
  logic [15:0] resp_cur = '0, exp_rdata = '0;
  logic [64:0] rec_d, rec_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
  );

  // PHY model: presents response bit k-48 after the rising edge of bit k
  assign mdi = (rcnt >= 49 && rcnt <= 64) ? resp_cur[64 - rcnt] : 1'b1;

  always @(posedge mdc) begin
    if (rcnt < 65) begin
      rec_d[64 - rcnt] = mdo;
      rec_e[64 - rcnt] = mdo_en;
    end
    rcnt = rcnt + 1;
  end

  always @(negedge clk) begin
    if (mdc) begin
      hi_run = hi_run + 1;
      if (lo_run != 0 && lo_run != HALF) bad_lo = bad_lo + 1;
      lo_run = 0;
    end else begin
      if (hi_run != 0 && hi_run != HALF) bad_hi = bad_hi + 1;
      hi_run = 0;
      if (busy) lo_run = lo_run + 1;
      else lo_run = 0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic r, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] resp, input bit inject);
    logic [64:0] ed, ee;
    int cycles;
    ed = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), pa, ra, 2'b00, (r ? 16'h0 : wd), 1'b0};
    ee = {{46{1'b1}}, 2'b00, {16{~r}}, 1'b0};
    if (r) exp_rdata = resp;
    @(negedge clk);
    resp_cur = resp; rcnt = 0; bad_hi = 0; bad_lo = 0;
    rec_d = '1; rec_e = '1;
    rd = r; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", 64'(busy), 64'd1);
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles = cycles + 1;
      if (inject && cycles == 40) begin
        start = 1'b1; rd = ~r; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk("R10 start-to-done cycles", 64'(cycles), 64'(131 * HALF));
    chk("R2 preamble data", 64'(rec_d[64:33]), 64'(ed[64:33]));
    chk("R2 preamble enable", 64'(rec_e[64:33]), 64'(ee[64:33]));
    chk("R3 start and opcode", 64'(rec_d[32:29]), 64'(ed[32:29]));
    chk("R4 addresses", 64'(rec_d[28:19]), 64'(ed[28:19]));
    chk("R4 address enable", 64'(rec_e[32:19]), 64'(ee[32:19]));
    chk("R5 turnaround enable", 64'(rec_e[18:17]), 64'd0);
    chk("R6 data field", 64'(rec_d[16:1]), 64'(ed[16:1]));
    chk("R6 data enable", 64'(rec_e[16:1]), 64'(ee[16:1]));
    chk("R7 rising edges", 64'(rcnt), 64'd65);
    chk("R7 last bit enable", 64'(rec_e[0]), 64'd0);
    chk("R8 half-period faults", 64'(bad_hi + bad_lo), 64'd0);
    chk("R12 released bits low", 64'(rec_d & ~ee), 64'd0);
    chk("R9 read data", 64'(rdata), 64'(exp_rdata));
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'd0);
    chk("R11 idle after frame", 64'({busy, mdc, mdo, mdo_en}), 64'd0);
    repeat (5) @(negedge clk);
    chk("R11 no second frame", 64'({busy, rcnt == 65}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 64'({mdc, mdo, mdo_en, busy, done}), 64'd0);
    chk("R1 reset rdata", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 64'({mdc, mdo, mdo_en, busy, done}), 64'd0);

    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

    // R11: start pulses mid-frame with other fields must be ignored
    run_frame(1'b0, 5'h03, 5'h04, 16'hBEEF, 16'h0000, 1'b1);
    run_frame(1'b1, 5'h11, 5'h06, 16'h0000, 16'h8001, 1'b1);
    // R9: a write right after a read keeps rdata
    run_frame(1'b0, 5'h1E, 5'h01, 16'h0001, 16'h7FFE, 1'b0);

    summary();
    $finish;
  end
endmodule